// File: doc/BRIEF.md
# Converter Control and Result Port

This block sits between a narrow synchronous register bus and an 8-bit converter. Software reaches it through two byte locations. Offset 0 is a control and status byte. Offset 1 is the result byte, which software can only read. From the control byte, software powers the converter, starts a conversion and enables an interrupt. The block drives a one-cycle start pulse and a power enable toward the converter. When the converter returns a done strobe with its result, the block captures the result and raises a completion flag.

The flag reads 1 after reset. A write cannot clear it; only an accepted start clears it. A start written while a conversion is under way abandons that conversion and begins a new one, and the abandoned value never reaches the result byte. Turning power off mid-conversion also abandons the conversion, and the flag stays 0. An interrupt request is raised whenever both the flag and its enable are 1. Software removes the request by clearing the enable.

The bus is a plain register port with no back-pressure. A write is taken on the clock edge where the write enable is high. Read data is combinational from the address. The converter side uses plain strobes, and nothing on that side waits for the block.

Top module: `adc_ctl`

## Requirements
- R1: After reset, offset 0 reads 0x40 (flag set, all else 0), and the power pin, start pin and interrupt are all low.
- R2: The control byte holds these fields: interrupt enable at bit 7, completion flag at bit 6, start at bit 5, power at bit 4 and oscillator-off at bit 2. Bits 7, 4 and 2 read back the value last written to them.
- R3: Writing 0 to bit 6 leaves the completion flag unchanged.
- R4: A write at offset 0 with bits 5 and 4 both 1 clears the flag on that clock edge. The block drives the start pin high for exactly the following cycle.
- R5: Bit 5 always reads 0.
- R6: A write with bit 5 at 1 and bit 4 at 0 is ignored. The flag keeps its value and no start pulse is driven.
- R7: A done strobe during a conversion sets the flag and loads the result into offset 1 on the same edge.
- R8: A start accepted during a conversion abandons it. Only the result of the last accepted start appears at offset 1.
- R9: The interrupt output is high exactly when bit 7 and bit 6 are both 1. Clearing bit 7 drops it.
- R10: The power pin follows bit 4. Writing bit 4 as 0 during a conversion abandons it, and the flag stays 0 even if a done strobe arrives later.
- R11: Bits 3, 1 and 0 read 0 whatever is written to them.
- R12: A done strobe while no conversion is in progress changes neither the flag nor the result byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register offset (0 control, 1 result) |
| bus_we | input | 1 | Write enable, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| conv_start | output | 1 | One-cycle start pulse to the converter |
| conv_pwr_en | output | 1 | Converter power enable |
| conv_done | input | 1 | Converter done strobe |
| conv_result | input | 8 | Converter result, valid with conv_done |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a done strobe from an abandoned conversion that arrives at or near the edge where a restart is accepted. The stimulus issues a second start at a sweep of delays after the first. The sweep runs up to the cycle in which the stub's done strobe fires, so restart and completion share an edge. The scoreboard expects only the value tied to the latest start. A late strobe after power-off, and a strobe forced while idle, cover the two other paths by which stale data could leak.

// File: rtl/adc_ctl_pkg.sv
package adc_ctl_pkg;
  localparam int REG_W   = 8;
  localparam int B_IE    = 7;
  localparam int B_FLAG  = 6;
  localparam int B_START = 5;
  localparam int B_PWR   = 4;
  localparam int B_OSC   = 2;

  typedef struct packed {
    logic ie;
    logic pwr;
    logic osc_off;
  } ctl_bits_t;
endpackage

// File: rtl/adc_ctl_regs.sv
module adc_ctl_regs
  import adc_ctl_pkg::*;
#(
  parameter int ADDR_W   = 1,
  parameter int CTL_OFS  = 0,
  parameter int DATA_OFS = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              flag,
  input  logic [REG_W-1:0]  result,
  output ctl_bits_t         ctl,
  output logic              start_req,
  output logic              pwr_off_req
);
  localparam logic [ADDR_W-1:0] CTL_A  = ADDR_W'(CTL_OFS);
  localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_OFS);

  logic wr_ctl;
  assign wr_ctl      = bus_we && (bus_addr == CTL_A);
  assign start_req   = wr_ctl && bus_wdata[B_START] && bus_wdata[B_PWR];
  assign pwr_off_req = wr_ctl && !bus_wdata[B_PWR];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl <= '0;
    end else if (wr_ctl) begin
      ctl.ie      <= bus_wdata[B_IE];
      ctl.pwr     <= bus_wdata[B_PWR];
      ctl.osc_off <= bus_wdata[B_OSC];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == CTL_A) begin
      bus_rdata[B_IE]   = ctl.ie;
      bus_rdata[B_FLAG] = flag;
      bus_rdata[B_PWR]  = ctl.pwr;
      bus_rdata[B_OSC]  = ctl.osc_off;
    end else if (bus_addr == DATA_A) begin
      bus_rdata = result;
    end
  end
endmodule

// File: rtl/adc_ctl_seq.sv
module adc_ctl_seq
  import adc_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic             pwr_off_req,
  input  logic             conv_done,
  input  logic [REG_W-1:0] conv_result,
  output logic             conv_start,
  output logic             flag,
  output logic [REG_W-1:0] result
);
  logic busy_q;
  logic done_ok;

  // A strobe is accepted only from the conversion most recently launched:
  // not on the edge of a new start, nor while the pulse is still in flight.
  assign done_ok = busy_q && conv_done && !conv_start && !start_req && !pwr_off_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      flag       <= 1'b1;
      result     <= '0;
      conv_start <= 1'b0;
    end else begin
      conv_start <= start_req;
      if (start_req) begin
        busy_q <= 1'b1;
        flag   <= 1'b0;
      end else if (pwr_off_req) begin
        busy_q <= 1'b0;
      end else if (done_ok) begin
        busy_q <= 1'b0;
        flag   <= 1'b1;
        result <= conv_result;
      end
    end
  end
endmodule

// File: rtl/adc_ctl.sv
module adc_ctl
  import adc_ctl_pkg::*;
#(
  parameter int ADDR_W   = 1,
  parameter int CTL_OFS  = 0,
  parameter int DATA_OFS = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              conv_start,
  output logic              conv_pwr_en,
  input  logic              conv_done,
  input  logic [7:0]        conv_result,
  output logic              irq
);
  ctl_bits_t        ctl;
  logic             start_req;
  logic             pwr_off_req;
  logic             eoc_flag;
  logic [REG_W-1:0] result;

  adc_ctl_regs #(.ADDR_W(ADDR_W), .CTL_OFS(CTL_OFS), .DATA_OFS(DATA_OFS)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_we      (bus_we),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .flag        (eoc_flag),
    .result      (result),
    .ctl         (ctl),
    .start_req   (start_req),
    .pwr_off_req (pwr_off_req)
  );

  adc_ctl_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_req   (start_req),
    .pwr_off_req (pwr_off_req),
    .conv_done   (conv_done),
    .conv_result (conv_result),
    .conv_start  (conv_start),
    .flag        (eoc_flag),
    .result      (result)
  );

  assign conv_pwr_en = ctl.pwr;
  assign irq         = ctl.ie && eoc_flag;
endmodule

// File: rtl/adc_ctl_chk.sv
module adc_ctl_chk #(
  parameter int ADDR_W = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic              conv_start,
  input logic              conv_pwr_en,
  input logic              irq,
  input logic              eoc
);
  logic wr0;
  assign wr0 = bus_we && (bus_addr == '0);

  // R4
  a_r4_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr0 && bus_wdata[5] && bus_wdata[4]) |=> (!eoc && conv_start));
  // R4
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && !(wr0 && bus_wdata[5] && bus_wdata[4])) |=> !conv_start);
  // R6
  a_r6_unpowered_start: assert property (@(posedge clk) disable iff (!rst_n)
    (wr0 && !bus_wdata[4]) |=> !conv_start);
  // R3
  a_r3_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (wr0 && !bus_wdata[5] && eoc) |=> eoc);
  // R10
  a_r10_abort_low: assert property (@(posedge clk) disable iff (!rst_n)
    (wr0 && !bus_wdata[4] && !eoc) |=> !eoc);
  // R10
  a_r10_start_powered: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> conv_pwr_en);
  // R5
  a_r5_start_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == '0) |-> !bus_rdata[5]);
  // R11
  a_r11_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == '0) |-> (!bus_rdata[3] && bus_rdata[1:0] == 2'b00));
  // R9
  a_r9_irq_matches: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == '0) |-> (irq == (bus_rdata[7] && bus_rdata[6])));
endmodule

bind adc_ctl adc_ctl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_addr    (bus_addr),
  .bus_we      (bus_we),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .conv_start  (conv_start),
  .conv_pwr_en (conv_pwr_en),
  .irq         (irq),
  .eoc         (eoc_flag)
);

// File: tb/test_adc_ctl.sv
module test_adc_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [0:0] bus_addr = 1'b1;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       conv_start, conv_pwr_en, conv_done, irq;
  logic [7:0] conv_result;

  int checks = 0;
  int fails  = 0;
  int n_starts = 0;
  logic [7:0] exp_q[$];
  logic [7:0] last_res = '0;
  logic force_done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_ctl i_adc_ctl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .conv_start(conv_start),
    .conv_pwr_en(conv_pwr_en), .conv_done(conv_done),
    .conv_result(conv_result), .irq(irq)
  );

  function automatic logic [7:0] res_fn(int idx);
    return 8'h3C ^ 8'(idx * 37 + 11);
  endfunction

  // Fixed-latency converter stub; it keeps counting even when unpowered.
  int         stub_cnt = 0;
  int         stub_idx = 0;
  logic [7:0] stub_res = '0;
  always @(posedge clk) begin
    if (conv_start) begin
      stub_cnt <= LAT;
      stub_res <= res_fn(stub_idx);
      stub_idx <= stub_idx + 1;
    end else if (stub_cnt != 0) begin
      stub_cnt <= stub_cnt - 1;
    end
  end
  assign conv_done   = (stub_cnt == 1) || force_done;
  assign conv_result = force_done ? 8'hEE : stub_res;

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] v);
    @(negedge clk);
    bus_addr = 1'b0; bus_we = 1'b1; bus_wdata = v;
    if (v[5] && v[4]) begin
      if (exp_q.size() > 0) void'(exp_q.pop_back());
      exp_q.push_back(res_fn(n_starts));
      n_starts++;
    end else if (!v[4] && exp_q.size() > 0) begin
      void'(exp_q.pop_back());
    end
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 1'b1;
  endtask

  task automatic rd(logic a, output logic [7:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
    bus_addr = 1'b1;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 100 && exp_q.size() > 0; i++) @(negedge clk);
  endtask

  // Scoreboard monitor: on each rise of the interrupt, the result byte must
  // match the oldest expected item (R7, R8).
  logic irq_prev = 1'b0;
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rst_n && irq && !irq_prev && exp_q.size() > 0 && bus_addr == 1'b1) begin
        last_res = exp_q.pop_front();
        chk("R7/R8 result", bus_rdata, last_res);
      end
      irq_prev = irq;
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    rd(1'b0, v); chk("R1 ctl", v, 8'h40);
    chk("R1 irq", {7'd0, irq}, 8'd0);
    chk("R1 pwr", {7'd0, conv_pwr_en}, 8'd0);
    chk("R1 start", {7'd0, conv_start}, 8'd0);
    // R6: start while unpowered
    wr(8'h20);
    chk("R6 no pulse", {7'd0, conv_start}, 8'd0);
    rd(1'b0, v); chk("R6 flag kept", v, 8'h40);
    // R3: writing 0 to the flag
    wr(8'h00);
    rd(1'b0, v); chk("R3 flag sticky", v, 8'h40);
    // R2, R11: all writable plus reserved bits
    wr(8'h9F);
    rd(1'b0, v); chk("R2/R11 readback", v, 8'hD4);
    chk("R9 irq on", {7'd0, irq}, 8'd1);
    chk("R10 pwr on", {7'd0, conv_pwr_en}, 8'd1);
    // R9: clearing enable removes request
    wr(8'h14);
    chk("R9 irq off", {7'd0, irq}, 8'd0);
    rd(1'b0, v); chk("R9 ctl", v, 8'h54);
    // R4, R5: a normal conversion
    wr(8'hB0);
    chk("R4 pulse", {7'd0, conv_start}, 8'd1);
    rd(1'b0, v); chk("R4/R5 ctl", v, 8'h90);
    @(negedge clk);
    chk("R4 pulse one cycle", {7'd0, conv_start}, 8'd0);
    wait_done();
    rd(1'b1, v); chk("R7 data", v, res_fn(0));
    rd(1'b0, v); chk("R7 flag", v, 8'hD0);
    // R8: restart sweep up to the completion edge
    for (int d = 0; d <= LAT + 1; d++) begin
      wr(8'hB0);
      repeat (d) @(negedge clk);
      wr(8'hB0);
      wait_done();
      rd(1'b1, v); chk("R8 last start only", v, res_fn(n_starts - 1));
    end
    // R10: power-off abort, late strobe must be ignored
    rd(1'b1, v);
    last_res = v;
    wr(8'hB0);
    @(negedge clk);
    wr(8'h80);
    chk("R10 pwr pin", {7'd0, conv_pwr_en}, 8'd0);
    repeat (LAT + 4) @(negedge clk);
    rd(1'b0, v); chk("R10 flag low", v, 8'h80);
    chk("R10 irq", {7'd0, irq}, 8'd0);
    rd(1'b1, v); chk("R10 data kept", v, last_res);
    // R12: idle strobe
    wr(8'h90);
    @(negedge clk);
    force_done = 1'b1;
    @(negedge clk);
    force_done = 1'b0;
    @(negedge clk);
    rd(1'b0, v); chk("R12 flag", v, 8'h90);
    rd(1'b1, v); chk("R12 data", v, last_res);
    // Back to normal operation
    wr(8'hB0);
    wait_done();
    rd(1'b1, v); chk("R7 after abort", v, res_fn(n_starts - 1));
    chk("R8 no leftover", 8'(exp_q.size()), 8'd0);
    finish_run();
  end
endmodule